// File: doc/BRIEF.md
# Program Address Sequencing Unit

This block produces the 16-bit address that a small processor core uses both to fetch instructions and to read coefficients. It holds a program counter that steps forward on each sequential fetch and reloads on jumps, calls, interrupt entry and the two kinds of return. Two separate return registers keep the resume point for a subroutine and for an interrupt service routine. The two are kept apart so that an interrupt taken inside a subroutine does not overwrite the subroutine's return point.

A coefficient pointer gives register-indirect addressing. After each coefficient access it moves on by a fixed +1, or by the contents of a signed 16-bit step register. The choice between the two is made on every access. A select input decides whether the program counter or the pointer drives the address output. The active address is decoded against one of four built-in memory maps into a one-hot enable. The enable picks the internal ROM, one of the 1K-word RAM banks, or the external ROM.

Top module: `prog_addr_seq`

## Requirements
- R1: After reset, the program counter, the coefficient pointer, both return registers and the step register all hold 0, so the address output reads 0 whichever source is selected.
- R2: When `op_i` is 1 (step), the program counter becomes its old value plus one, modulo 2^16, so 0xFFFF is followed by 0x0000.
- R3: When `op_i` is 2 (jump), the program counter loads `target_i`.
- R4: When `op_i` is 3 (call), the subroutine return register takes the program counter plus one and the program counter loads `target_i`. When `op_i` is 4 (return), the program counter reloads from the subroutine return register.
- R5: When `op_i` is 5 (interrupt entry), the interrupt return register takes the current program counter and the program counter loads `target_i`. When `op_i` is 6 (return from interrupt), the program counter reloads from the interrupt return register. Neither of these operations alters the subroutine return register.
- R6: When `op_i` is 0 (hold) or 7 (unused), the program counter and both return registers keep their values.
- R7: When `ptr_load_i` is high, the pointer loads `ptr_data_i`. This load takes priority over a postincrement requested in the same cycle.
- R8: A coefficient access is a cycle in which `req_i` and `coef_sel_i` are both high. On a coefficient access without a load, the pointer adds the step register (as 16-bit two's complement) when `use_step_i` is high, and adds 1 otherwise, modulo 2^16. In any other cycle the pointer is unchanged.
- R9: When `step_load_i` is high, the step register loads `step_data_i` at the clock edge. A postincrement in that same cycle still uses the old step value.
- R10: `addr_o` shows the pointer when `coef_sel_i` is 1 and the program counter when it is 0.
- R11: Segment decode follows `map_sel_i`. Map 0 places the internal ROM at 0x0000 and the RAM banks from 0x8000. Map 1 has no internal ROM and places the RAM banks from 0x8000. Map 2 places the RAM banks from 0x0000 and the internal ROM at 0x8000. Map 3 places the RAM banks from 0x0000 and has no internal ROM. The internal ROM is ROM_WORDS long, and each RAM bank is 1024 words in consecutive order. Every other address selects the external ROM. Enable bit 0 is the internal ROM, bits 1..NRAM_BANKS are RAM banks 0 upward, and bit NRAM_BANKS+1 is the external ROM.
- R12: Exactly one bit of `seg_en_o` is high in every cycle with `req_i` high, and none is high when `req_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| map_sel_i | input | 2 | Memory map selection |
| op_i | input | 3 | Program counter operation code |
| target_i | input | ADDR_W | Jump, call or interrupt vector target |
| ptr_load_i | input | 1 | Load the coefficient pointer |
| ptr_data_i | input | ADDR_W | Value for a pointer load |
| step_load_i | input | 1 | Load the signed step register |
| step_data_i | input | ADDR_W | Value for a step load |
| use_step_i | input | 1 | Postincrement by step register (1) or by +1 (0) |
| coef_sel_i | input | 1 | Address source: 1 pointer, 0 program counter |
| req_i | input | 1 | Memory access requested this cycle |
| addr_o | output | ADDR_W | Active instruction/coefficient address |
| seg_en_o | output | NRAM_BANKS+2 | One-hot memory segment enable |

## Verification
The bench builds the block with NRAM_BANKS=3 and ROM_WORDS=2048. With these values, three bank edges and a ROM end at 0x0800 or 0x8800 fall inside a small set of addresses the bench aims at. With three banks, the bank index carries more than a single bit, and the RAM region ends at 0x0C00 or 0x8C00 rather than on a power-of-two edge. Directed pointer loads at both sides of every edge, in all four maps, then exercise each segment choice and its neighbour.

// File: rtl/pas_pkg.sv
package pas_pkg;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_STEP = 3'd1,
    OP_JUMP = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_IRQ  = 3'd5,
    OP_RETI = 3'd6
  } pas_op_e;

  typedef struct packed {
    logic rom_present;
    logic rom_upper;
    logic ram_upper;
  } pas_map_t;

  function automatic pas_map_t pas_map_lookup(input logic [1:0] sel);
    pas_map_t m;
    case (sel)
      2'd0:    m = '{rom_present: 1'b1, rom_upper: 1'b0, ram_upper: 1'b1};
      2'd1:    m = '{rom_present: 1'b0, rom_upper: 1'b0, ram_upper: 1'b1};
      2'd2:    m = '{rom_present: 1'b1, rom_upper: 1'b1, ram_upper: 1'b0};
      default: m = '{rom_present: 1'b0, rom_upper: 1'b0, ram_upper: 1'b0};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pas_rst_sync.sv
module pas_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_ok_n = sync_q;
endmodule

// File: rtl/pas_pc_unit.sv
module pas_pc_unit
  import pas_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sub_ret_o,
  output logic [ADDR_W-1:0] irq_ret_o
);
  localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);
  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] sub_q, sub_d;
  logic [ADDR_W-1:0] irt_q, irt_d;
  logic              pc_en, sub_en, irt_en;
  logic [ADDR_W-1:0] pc_inc;

  assign pc_inc = pc_q + ONE;

  // next-state
  always_comb begin
    pc_en  = 1'b0;
    sub_en = 1'b0;
    irt_en = 1'b0;
    pc_d   = pc_q;
    sub_d  = sub_q;
    irt_d  = irt_q;
    case (op_i)
      OP_STEP: begin
        pc_en = 1'b1;
        pc_d  = pc_inc;
      end
      OP_JUMP: begin
        pc_en = 1'b1;
        pc_d  = target_i;
      end
      OP_CALL: begin
        pc_en  = 1'b1;
        pc_d   = target_i;
        sub_en = 1'b1;
        sub_d  = pc_inc;
      end
      OP_RET: begin
        pc_en = 1'b1;
        pc_d  = sub_q;
      end
      OP_IRQ: begin
        pc_en  = 1'b1;
        pc_d   = target_i;
        irt_en = 1'b1;
        irt_d  = pc_q;
      end
      OP_RETI: begin
        pc_en = 1'b1;
        pc_d  = irt_q;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= PC_INIT;
      sub_q <= '0;
      irt_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (sub_en) sub_q <= sub_d;
      if (irt_en) irt_q <= irt_d;
    end
  end

  assign pc_o      = pc_q;
  assign sub_ret_o = sub_q;
  assign irq_ret_o = irt_q;
endmodule

// File: rtl/pas_ptr_unit.sv
module pas_ptr_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load_i,
  input  logic [ADDR_W-1:0] ptr_data_i,
  input  logic              step_load_i,
  input  logic [ADDR_W-1:0] step_data_i,
  input  logic              use_step_i,
  input  logic              access_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] step_o
);
  localparam logic [ADDR_W-1:0] UNIT = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] step_q, step_d;
  logic              ptr_en, step_en;
  logic [ADDR_W-1:0] delta;

  // two's complement add wraps naturally at ADDR_W bits
  assign delta = use_step_i ? step_q : UNIT;

  always_comb begin
    ptr_en = 1'b0;
    ptr_d  = ptr_q;
    if (ptr_load_i) begin
      ptr_en = 1'b1;
      ptr_d  = ptr_data_i;
    end else if (access_i) begin
      ptr_en = 1'b1;
      ptr_d  = ptr_q + delta;
    end
  end

  always_comb begin
    step_en = step_load_i;
    step_d  = step_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      step_q <= '0;
    end else begin
      if (ptr_en)  ptr_q  <= ptr_d;
      if (step_en) step_q <= step_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign step_o = step_q;
endmodule

// File: rtl/pas_seg_decode.sv
module pas_seg_decode
  import pas_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NRAM_BANKS = 2,
  parameter int ROM_WORDS  = 4096,
  parameter int BANK_WORDS = 1024
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [1:0]            map_sel_i,
  input  logic                  req_i,
  output logic [NRAM_BANKS+1:0] seg_en_o
);
  localparam int                NSEG    = NRAM_BANKS + 2;
  localparam int                BANK_LG = $clog2(BANK_WORDS);
  localparam logic [ADDR_W-1:0] HALF_V  = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W:0]   ROM_LIM = (ADDR_W+1)'(ROM_WORDS);
  localparam logic [ADDR_W:0]   RAM_LIM = (ADDR_W+1)'(NRAM_BANKS * BANK_WORDS);

  pas_map_t          cfg;
  logic [ADDR_W-1:0] rom_base, ram_base;
  logic [ADDR_W-1:0] off_rom, off_ram;
  logic              above_rom, above_ram;
  logic              in_rom, in_ram;
  logic [ADDR_W-1:0] bank_idx;
  logic [NRAM_BANKS-1:0] bank_hit;

  assign cfg       = pas_map_lookup(map_sel_i);
  assign rom_base  = cfg.rom_upper ? HALF_V : '0;
  assign ram_base  = cfg.ram_upper ? HALF_V : '0;
  assign above_rom = cfg.rom_upper ? addr_i[ADDR_W-1] : 1'b1;
  assign above_ram = cfg.ram_upper ? addr_i[ADDR_W-1] : 1'b1;
  assign off_rom   = addr_i - rom_base;
  assign off_ram   = addr_i - ram_base;
  assign in_rom    = cfg.rom_present && above_rom && ({1'b0, off_rom} < ROM_LIM);
  assign in_ram    = above_ram && ({1'b0, off_ram} < RAM_LIM);
  assign bank_idx  = off_ram >> BANK_LG;

  for (genvar g = 0; g < NRAM_BANKS; g++) begin : g_bank
    assign bank_hit[g] = in_ram && (bank_idx == ADDR_W'(g));
  end

  always_comb begin
    seg_en_o = '0;
    if (req_i) begin
      if (in_ram) begin
        seg_en_o[NRAM_BANKS:1] = bank_hit;
      end else if (in_rom) begin
        seg_en_o[0] = 1'b1;
      end else begin
        seg_en_o[NSEG-1] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prog_addr_seq.sv
module prog_addr_seq #(
  parameter int          ADDR_W     = 16,
  parameter int          NRAM_BANKS = 2,
  parameter int          ROM_WORDS  = 4096,
  parameter int          BANK_WORDS = 1024,
  parameter logic [15:0] RESET_PC   = 16'h0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            map_sel_i,
  input  logic [2:0]            op_i,
  input  logic [ADDR_W-1:0]     target_i,
  input  logic                  ptr_load_i,
  input  logic [ADDR_W-1:0]     ptr_data_i,
  input  logic                  step_load_i,
  input  logic [ADDR_W-1:0]     step_data_i,
  input  logic                  use_step_i,
  input  logic                  coef_sel_i,
  input  logic                  req_i,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [NRAM_BANKS+1:0] seg_en_o
);
  localparam int NSEG = NRAM_BANKS + 2;

  logic              rst_ok_n;
  logic [ADDR_W-1:0] pc_q, sub_q, irt_q;
  logic [ADDR_W-1:0] ptr_q, step_q;
  logic              coef_access;

  assign coef_access = req_i & coef_sel_i;

  pas_rst_sync u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_n (rst_ok_n)
  );

  pas_pc_unit #(
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk       (clk),
    .rst_n     (rst_ok_n),
    .op_i      (op_i),
    .target_i  (target_i),
    .pc_o      (pc_q),
    .sub_ret_o (sub_q),
    .irq_ret_o (irt_q)
  );

  pas_ptr_unit #(
    .ADDR_W (ADDR_W)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_ok_n),
    .ptr_load_i  (ptr_load_i),
    .ptr_data_i  (ptr_data_i),
    .step_load_i (step_load_i),
    .step_data_i (step_data_i),
    .use_step_i  (use_step_i),
    .access_i    (coef_access),
    .ptr_o       (ptr_q),
    .step_o      (step_q)
  );

  assign addr_o = coef_sel_i ? ptr_q : pc_q;

  pas_seg_decode #(
    .ADDR_W     (ADDR_W),
    .NRAM_BANKS (NRAM_BANKS),
    .ROM_WORDS  (ROM_WORDS),
    .BANK_WORDS (BANK_WORDS)
  ) u_dec (
    .addr_i    (addr_o),
    .map_sel_i (map_sel_i),
    .req_i     (req_i),
    .seg_en_o  (seg_en_o)
  );
endmodule

// File: rtl/pas_checker.sv
module pas_checker
  import pas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NSEG   = 4
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic [2:0]        op_i,
  input logic [ADDR_W-1:0] target_i,
  input logic              ptr_load_i,
  input logic [ADDR_W-1:0] ptr_data_i,
  input logic              use_step_i,
  input logic              coef_sel_i,
  input logic              req_i,
  input logic [NSEG-1:0]   seg_en_o,
  input logic [ADDR_W-1:0] pc_q,
  input logic [ADDR_W-1:0] sub_q,
  input logic [ADDR_W-1:0] irt_q,
  input logic [ADDR_W-1:0] ptr_q,
  input logic [ADDR_W-1:0] step_q
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i == OP_STEP) |=> (pc_q == $past(pc_q) + ONE));

  assert_pc_jump_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i == OP_JUMP) |=> (pc_q == $past(target_i)));

  assert_call_link_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i == OP_CALL) |=> (sub_q == $past(pc_q) + ONE && pc_q == $past(target_i)));

  assert_ret_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i == OP_RET) |=> (pc_q == $past(sub_q)));

  assert_irq_link_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i == OP_IRQ) |=> (irt_q == $past(pc_q) && $stable(sub_q)));

  assert_reti_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i == OP_RETI) |=> (pc_q == $past(irt_q) && $stable(sub_q)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i == OP_HOLD || op_i == 3'd7) |=> ($stable(pc_q) && $stable(sub_q) && $stable(irt_q)));

  assert_ptr_load_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ptr_load_i |=> (ptr_q == $past(ptr_data_i)));

  assert_ptr_unit_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!ptr_load_i && req_i && coef_sel_i && !use_step_i) |=> (ptr_q == $past(ptr_q) + ONE));

  assert_ptr_signed_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!ptr_load_i && req_i && coef_sel_i && use_step_i) |=> (ptr_q == $past(ptr_q) + $past(step_q)));

  assert_ptr_idle_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!ptr_load_i && !(req_i && coef_sel_i)) |=> $stable(ptr_q));

  assert_seg_onehot_R12: assert property (@(posedge clk) disable iff (!rst_ok_n)
    req_i |-> ($countones(seg_en_o) == 1));

  assert_seg_quiet_R12: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !req_i |-> (seg_en_o == '0));
endmodule

bind prog_addr_seq pas_checker #(
  .ADDR_W (ADDR_W),
  .NSEG   (NSEG)
) u_chk (
  .clk        (clk),
  .rst_ok_n   (rst_ok_n),
  .op_i       (op_i),
  .target_i   (target_i),
  .ptr_load_i (ptr_load_i),
  .ptr_data_i (ptr_data_i),
  .use_step_i (use_step_i),
  .coef_sel_i (coef_sel_i),
  .req_i      (req_i),
  .seg_en_o   (seg_en_o),
  .pc_q       (pc_q),
  .sub_q      (sub_q),
  .irt_q      (irt_q),
  .ptr_q      (ptr_q),
  .step_q     (step_q)
);

// File: tb/prog_addr_seq_tb_top.sv
module prog_addr_seq_tb_top;
  localparam int NRAM = 3;
  localparam int ROMW = 2048;
  localparam int NSEG = NRAM + 2;

  logic            clk;
  logic            rst_n;
  logic [1:0]      map_sel_i;
  logic [2:0]      op_i;
  logic [15:0]     target_i;
  logic            ptr_load_i;
  logic [15:0]     ptr_data_i;
  logic            step_load_i;
  logic [15:0]     step_data_i;
  logic            use_step_i;
  logic            coef_sel_i;
  logic            req_i;
  logic [15:0]     addr_o;
  logic [NSEG-1:0] seg_en_o;

  int total;
  int bad;
  bit done;

  logic [15:0] m_pc, m_sub, m_irt, m_ptr, m_step;

  prog_addr_seq #(
    .ADDR_W     (16),
    .NRAM_BANKS (NRAM),
    .ROM_WORDS  (ROMW),
    .BANK_WORDS (1024),
    .RESET_PC   (16'h0000)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .map_sel_i   (map_sel_i),
    .op_i        (op_i),
    .target_i    (target_i),
    .ptr_load_i  (ptr_load_i),
    .ptr_data_i  (ptr_data_i),
    .step_load_i (step_load_i),
    .step_data_i (step_data_i),
    .use_step_i  (use_step_i),
    .coef_sel_i  (coef_sel_i),
    .req_i       (req_i),
    .addr_o      (addr_o),
    .seg_en_o    (seg_en_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [NSEG-1:0] exp_seg(input int a, input int mp, input bit rq);
    int  rom_lo;
    int  ram_lo;
    bit  rom_on;
    rom_on = (mp == 0) || (mp == 2);
    rom_lo = (mp == 2) ? 32768 : 0;
    ram_lo = (mp < 2) ? 32768 : 0;
    if (!rq) return '0;
    if (a >= ram_lo && a < ram_lo + NRAM * 1024)
      return NSEG'(1) << (1 + (a - ram_lo) / 1024);
    if (rom_on && a >= rom_lo && a < rom_lo + ROMW)
      return NSEG'(1);
    return NSEG'(1) << (NRAM + 1);
  endfunction

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: addr_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    op_i        = 3'd0;
    target_i    = '0;
    ptr_load_i  = 1'b0;
    ptr_data_i  = '0;
    step_load_i = 1'b0;
    step_data_i = '0;
    use_step_i  = 1'b0;
    coef_sel_i  = 1'b0;
    req_i       = 1'b0;
  endtask

  // check combinational outputs, then advance one clock and the model
  task automatic tick(input string tag);
    logic [15:0] exp_a;
    logic [NSEG-1:0] es;
    logic [15:0] inc;
    #1;
    exp_a = coef_sel_i ? m_ptr : m_pc;
    check16(tag, addr_o, exp_a);
    es = exp_seg(int'(exp_a), int'(map_sel_i), req_i);
    total++;
    if (seg_en_o !== es) begin
      bad++;
      $display("FAIL %s/R11/R12: seg_en_o=%b expected %b (addr %h map %0d)",
               tag, seg_en_o, es, exp_a, map_sel_i);
    end
    @(posedge clk);
    inc = use_step_i ? m_step : 16'd1;
    if (ptr_load_i) m_ptr = ptr_data_i;
    else if (req_i && coef_sel_i) m_ptr = m_ptr + inc;
    if (step_load_i) m_step = step_data_i;
    case (op_i)
      3'd1: m_pc = m_pc + 16'd1;
      3'd2: m_pc = target_i;
      3'd3: begin m_sub = m_pc + 16'd1; m_pc = target_i; end
      3'd4: m_pc = m_sub;
      3'd5: begin m_irt = m_pc; m_pc = target_i; end
      3'd6: m_pc = m_irt;
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic pc_op(input logic [2:0] op, input logic [15:0] tgt, input string tag);
    idle_in();
    op_i = op;
    target_i = tgt;
    tick(tag);
  endtask

  task automatic look_pc(input string tag);
    idle_in();
    tick(tag);
  endtask

  function automatic logic [15:0] pick_addr();
    int r;
    int edges [14];
    edges = '{0, ROMW, 1024, 2048, 3072, 32767, 32768, 32768 + ROMW,
              33792, 34816, 35840, 65535, 4096, 12288};
    r = int'($urandom % 3);
    if (r == 0) return 16'($urandom);
    return 16'(edges[$urandom % 14] + int'($urandom % 3) - 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, cycles=200000 expected fewer");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0;
    bad = 0;
    done = 1'b0;
    void'($urandom(32'h5eed));
    idle_in();
    map_sel_i = 2'd0;
    m_pc = 0; m_sub = 0; m_irt = 0; m_ptr = 0; m_step = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state on both sources; step register reset to 0
    look_pc("R1 pc");
    idle_in(); coef_sel_i = 1'b1; tick("R1 ptr");
    idle_in(); coef_sel_i = 1'b1; req_i = 1'b1; use_step_i = 1'b1; tick("R1 step");
    idle_in(); coef_sel_i = 1'b1; tick("R1 step zero keeps ptr");

    // R3 / R2: jump near top, step across the wrap
    pc_op(3'd2, 16'hFFFE, "R3 jump");
    pc_op(3'd1, 16'h0, "R2 step");
    pc_op(3'd1, 16'h0, "R2 step");
    look_pc("R2 wrap");

    // R4: call and return
    pc_op(3'd2, 16'h1234, "R3");
    pc_op(3'd3, 16'h5000, "R4 call");
    pc_op(3'd1, 16'h0, "R4 body");
    pc_op(3'd4, 16'h0, "R4 ret");
    look_pc("R4 back");

    // R5: interrupt inside subroutine, returns in nested order
    pc_op(3'd2, 16'h2000, "R3");
    pc_op(3'd3, 16'h3000, "R4 call");
    pc_op(3'd5, 16'h0040, "R5 irq");
    pc_op(3'd1, 16'h0, "R5 isr");
    pc_op(3'd6, 16'h0, "R5 reti");
    pc_op(3'd4, 16'h0, "R5 sub kept");
    look_pc("R5 final");

    // R6: hold and unused code
    pc_op(3'd0, 16'hAAAA, "R6 hold");
    pc_op(3'd7, 16'h5555, "R6 unused");
    look_pc("R6 kept");

    // R7: load beats same-cycle postincrement
    idle_in(); coef_sel_i = 1'b1; req_i = 1'b1; ptr_load_i = 1'b1; ptr_data_i = 16'h8BFF;
    tick("R7 load");
    // R9: step load with postincrement uses old step (0)
    idle_in(); coef_sel_i = 1'b1; req_i = 1'b1; use_step_i = 1'b1;
    step_load_i = 1'b1; step_data_i = 16'hFFFE;
    tick("R9 old step");
    // R8: signed -2, then unit
    idle_in(); coef_sel_i = 1'b1; req_i = 1'b1; use_step_i = 1'b1; tick("R8 signed");
    idle_in(); coef_sel_i = 1'b1; req_i = 1'b1; tick("R8 unit");
    // R8: no access without request, none when pc selected
    idle_in(); coef_sel_i = 1'b1; tick("R8 no req");
    idle_in(); req_i = 1'b1; tick("R10 pc source");
    idle_in(); coef_sel_i = 1'b1; tick("R8 unchanged");
    // R8 wrap below zero
    idle_in(); ptr_load_i = 1'b1; ptr_data_i = 16'h0000; step_load_i = 1'b1; step_data_i = 16'hFFFF;
    tick("R7");
    idle_in(); coef_sel_i = 1'b1; req_i = 1'b1; use_step_i = 1'b1; tick("R8 wrap");
    idle_in(); coef_sel_i = 1'b1; req_i = 1'b1; use_step_i = 1'b1;
    step_load_i = 1'b1; step_data_i = 16'd5; tick("R9 same cycle");
    idle_in(); coef_sel_i = 1'b1; req_i = 1'b1; use_step_i = 1'b1; tick("R9 new step");
    idle_in(); coef_sel_i = 1'b1; tick("R8 R10");

    // R11 / R12: every edge under every map
    for (int mp = 0; mp < 4; mp++) begin
      for (int e = 0; e < 16; e++) begin
        int a;
        case (e)
          0: a = 0;        1: a = ROMW - 1;   2: a = ROMW;     3: a = 1023;
          4: a = 1024;     5: a = 3071;       6: a = 3072;     7: a = 32767;
          8: a = 32768;    9: a = 32768 + ROMW - 1;            10: a = 32768 + ROMW;
          11: a = 33791;   12: a = 34816;     13: a = 35839;   14: a = 35840;
          default: a = 65535;
        endcase
        idle_in(); map_sel_i = 2'(mp); ptr_load_i = 1'b1; ptr_data_i = 16'(a);
        tick("R11 load");
        idle_in(); coef_sel_i = 1'b1; req_i = 1'b1; tick("R11 R12 edge");
        idle_in(); coef_sel_i = 1'b1; tick("R12 quiet");
      end
    end

    // random mix
    for (int n = 0; n < 6000; n++) begin
      int r;
      idle_in();
      r = int'($urandom % 8);
      op_i        = 3'(r);
      target_i    = pick_addr();
      ptr_load_i  = ($urandom % 6) == 0;
      ptr_data_i  = pick_addr();
      step_load_i = ($urandom % 8) == 0;
      step_data_i = (($urandom % 2) == 0) ? 16'($urandom % 5) - 16'd2 : 16'($urandom);
      use_step_i  = 1'($urandom);
      coef_sel_i  = 1'($urandom);
      req_i       = ($urandom % 4) != 0;
      if (($urandom % 64) == 0) map_sel_i = 2'($urandom);
      tick("R10 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule